// File: doc/BRIEF.md
# Card Data Bus Width Register

This block keeps the data bus width that a memory card currently uses. It watches decoded command strobes and changes the width when one of two configuration commands arrives. The first is an MMC-style SWITCH that writes one byte of the extended configuration space. The second is an SD-style application command, which is index 6 sent right after an application prefix (index 55). Index 6 without that prefix is taken as a SWITCH. Invalid requests are refused and the width stays as it was. A refused SWITCH sets a sticky error flag. A refused application command raises a one-cycle illegal-command pulse.

The block tracks the application prefix itself. A prefix applies to the next command only, whatever that command is. The go-idle command (index 0) returns everything to the power-up state: 1-bit width, no error, no pending prefix. The width register can only be written, and only the decoded width code leaves the block, so a lane multiplexer elsewhere can use it.

Top module: `bw_mode_reg`

## Requirements
- R1: After synchronous reset, `bus_width` is 2'b00 (1 bit), and `switch_err` and `illegal_cmd` are 0.
- R2: A SWITCH command (index 6, no pending prefix) has access field arg[25:24]=2'b11, byte index arg[23:16]=183 and value arg[15:8]. A value of 0, 1 or 2 sets `bus_width` to 2'b00, 2'b01 or 2'b10 (1, 4 or 8 bits) and clears `switch_err`. Outputs are valid one clock after the strobe.
- R3: A SWITCH to byte 183 with a value above 2 leaves `bus_width` unchanged and sets `switch_err`.
- R4: A SWITCH whose byte index is not 183, or whose access field is not 2'b11, changes neither `bus_width` nor `switch_err`.
- R5: Index 6 right after index 55, with `card_state` equal to 4 (transfer), uses arg[1:0]. 2'b00 selects 1 bit (code 2'b00) and 2'b10 selects 4 bits (code 2'b01).
- R6: An application width command with arg[1:0] of 2'b01 or 2'b11 leaves `bus_width` unchanged and pulses `illegal_cmd`.
- R7: An application width command with `card_state` not equal to 4 leaves `bus_width` unchanged and pulses `illegal_cmd`.
- R8: The prefix from index 55 applies to exactly the next command. If any other command comes in between, a following index 6 is a SWITCH. Back-to-back index 55 commands keep the prefix pending.
- R9: Index 0 sets `bus_width` to 2'b00, clears `switch_err` and cancels any pending prefix.
- R10: `illegal_cmd` is high for exactly one cycle after a refused command and is low in every cycle not preceded by a strobe.
- R11: While `cmd_valid` is low, the other inputs have no effect on `bus_width` or `switch_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| card_state | input | 4 | Current card state (4 = transfer) |
| bus_width | output | 2 | Active width code: 00=1 bit, 01=4 bits, 10=8 bits |
| switch_err | output | 1 | Sticky flag for a refused SWITCH width write |
| illegal_cmd | output | 1 | One-cycle pulse for a refused application width command |

## Verification
The hardest case to reach is the lifetime of the application prefix. Whether index 6 goes down the SD path or the SWITCH path depends on what came one command earlier, and that state is never visible at the ports. The stimulus makes it visible by sending an argument that means something different on each path: a SWITCH value of 8 bits, whose low argument bits would select 1 bit as an application command. The resulting width then shows which path was taken. The sequences are prefix–other–6, prefix–prefix–6 and prefix–go-idle–6.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic [1:0] {
    BW_1 = 2'd0,
    BW_4 = 2'd1,
    BW_8 = 2'd2
  } bw_code_e;

  localparam int IDX_W = 6;
  localparam logic [IDX_W-1:0] CMD_GO_IDLE = 6'd0;
  localparam logic [IDX_W-1:0] CMD_WIDTH   = 6'd6;
  localparam logic [IDX_W-1:0] CMD_APP     = 6'd55;
endpackage

// File: rtl/bw_app_track.sv
module bw_app_track
  import bw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [IDX_W-1:0] cmd_index,
  output logic             app_pending
);
  always_ff @(posedge clk) begin
    if (rst) app_pending <= 1'b0;
    else if (cmd_valid) app_pending <= (cmd_index == CMD_APP);
  end

  assert_prefix_one_shot_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_index != CMD_APP) |=> !app_pending);
endmodule

// File: rtl/bw_switch_dec.sv
module bw_switch_dec
  import bw_pkg::*;
#(
  parameter int ARG_W     = 32,
  parameter int BYTE_IDX  = 183,
  parameter int ACC_LSB   = 24,
  parameter int IDX_LSB   = 16,
  parameter int VAL_LSB   = 8
) (
  input  logic [ARG_W-1:0] arg,
  output logic             hit,
  output logic             ok,
  output bw_code_e         code
);
  localparam logic [1:0] ACC_WRITE = 2'b11;
  logic [1:0] acc;
  logic [7:0] idx;
  logic [7:0] val;

  always_comb begin
    acc  = arg[ACC_LSB +: 2];
    idx  = arg[IDX_LSB +: 8];
    val  = arg[VAL_LSB +: 8];
    hit  = (acc == ACC_WRITE) && (idx == 8'(BYTE_IDX));
    ok   = (val <= 8'd2);
    unique case (val)
      8'd1:    code = BW_4;
      8'd2:    code = BW_8;
      default: code = BW_1;
    endcase
  end
endmodule

// File: rtl/bw_acmd_dec.sv
module bw_acmd_dec
  import bw_pkg::*;
#(
  parameter int ARG_W      = 32,
  parameter int STATE_W    = 4,
  parameter int TRAN_STATE = 4
) (
  input  logic [ARG_W-1:0]   arg,
  input  logic [STATE_W-1:0] state,
  output logic               ok,
  output bw_code_e           code
);
  logic code_ok;
  always_comb begin
    unique case (arg[1:0])
      2'b00:   begin code = BW_1; code_ok = 1'b1; end
      2'b10:   begin code = BW_4; code_ok = 1'b1; end
      default: begin code = BW_1; code_ok = 1'b0; end
    endcase
    ok = code_ok && (state == STATE_W'(TRAN_STATE));
  end
endmodule

// File: rtl/bw_mode_reg.sv
module bw_mode_reg
  import bw_pkg::*;
#(
  parameter int ARG_W      = 32,
  parameter int STATE_W    = 4,
  parameter int TRAN_STATE = 4,
  parameter int BYTE_IDX   = 183
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [5:0]         cmd_index,
  input  logic [ARG_W-1:0]   cmd_arg,
  input  logic [STATE_W-1:0] card_state,
  output logic [1:0]         bus_width,
  output logic               switch_err,
  output logic               illegal_cmd
);
  logic     app_pending;
  logic     sw_hit, sw_ok, ac_ok;
  bw_code_e sw_code, ac_code;
  bw_code_e width_q;
  logic     is_idle, is_acmd, is_switch;

  bw_app_track u_track (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
    .cmd_index(cmd_index), .app_pending(app_pending)
  );

  bw_switch_dec #(.ARG_W(ARG_W), .BYTE_IDX(BYTE_IDX)) u_sw (
    .arg(cmd_arg), .hit(sw_hit), .ok(sw_ok), .code(sw_code)
  );

  bw_acmd_dec #(.ARG_W(ARG_W), .STATE_W(STATE_W), .TRAN_STATE(TRAN_STATE)) u_ac (
    .arg(cmd_arg), .state(card_state), .ok(ac_ok), .code(ac_code)
  );

  always_comb begin
    is_idle   = cmd_valid && (cmd_index == CMD_GO_IDLE);
    is_acmd   = cmd_valid && (cmd_index == CMD_WIDTH) && app_pending;
    is_switch = cmd_valid && (cmd_index == CMD_WIDTH) && !app_pending;
  end

  always_ff @(posedge clk) begin
    if (rst || is_idle) begin
      width_q     <= BW_1;
      switch_err  <= 1'b0;
      illegal_cmd <= 1'b0;
    end else begin
      illegal_cmd <= 1'b0;
      if (is_switch && sw_hit) begin
        if (sw_ok) begin
          width_q    <= sw_code;
          switch_err <= 1'b0;
        end else begin
          switch_err <= 1'b1;
        end
      end
      if (is_acmd) begin
        if (ac_ok) width_q <= ac_code;
        else       illegal_cmd <= 1'b1;
      end
    end
  end

  assign bus_width = width_q;

  assert_width_legal_R2: assert property (@(posedge clk) disable iff (rst)
    bus_width != 2'b11);
  assert_bad_switch_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (is_switch && sw_hit && !sw_ok) |=> ($stable(bus_width) && switch_err));
  assert_off_state_refused_R7: assert property (@(posedge clk) disable iff (rst)
    (is_acmd && card_state != STATE_W'(TRAN_STATE)) |=> ($stable(bus_width) && illegal_cmd));
  assert_idle_default_R9: assert property (@(posedge clk) disable iff (rst)
    is_idle |=> (bus_width == 2'b00 && !switch_err));
  assert_pulse_needs_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !illegal_cmd);
  assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(bus_width) && $stable(switch_err)));
endmodule

// File: tb/bw_mode_reg_test.sv
module bw_mode_reg_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic [3:0]  card_state;
  logic [1:0]  bus_width;
  logic        switch_err;
  logic        illegal_cmd;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bw_mode_reg uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .card_state(card_state), .bus_width(bus_width),
    .switch_err(switch_err), .illegal_cmd(illegal_cmd)
  );

  function automatic logic [31:0] sw_arg(input logic [1:0] acc, input logic [7:0] idx,
                                         input logic [7:0] val);
    return {6'd0, acc, idx, val, 8'h00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] idx, input logic [31:0] arg, input logic [3:0] st);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = idx; cmd_arg = arg; card_state = st;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; cmd_valid = 1'b0; cmd_index = '0; cmd_arg = '0; card_state = 4'd4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 width", bus_width, 2'b00);
    check("R1 err", switch_err, 1'b0);
    check("R1 illegal", illegal_cmd, 1'b0);
  endtask

  task automatic t_switch_valid;
    send(6, sw_arg(2'b11, 8'd183, 8'd1), 4'd4); check("R2 to 4", bus_width, 2'b01);
    send(6, sw_arg(2'b11, 8'd183, 8'd2), 4'd4); check("R2 to 8", bus_width, 2'b10);
    send(6, sw_arg(2'b11, 8'd183, 8'd0), 4'd4); check("R2 to 1", bus_width, 2'b00);
    send(6, sw_arg(2'b11, 8'd183, 8'd2), 4'd4); check("R2 to 8 again", bus_width, 2'b10);
  endtask

  task automatic t_switch_invalid;
    send(6, sw_arg(2'b11, 8'd183, 8'd3), 4'd4);
    check("R3 width kept", bus_width, 2'b10);
    check("R3 err set", switch_err, 1'b1);
    send(6, sw_arg(2'b11, 8'd183, 8'hFF), 4'd4);
    check("R3 width kept ff", bus_width, 2'b10);
    send(6, sw_arg(2'b11, 8'd183, 8'd1), 4'd4);
    check("R2 err cleared", switch_err, 1'b0);
    check("R2 width 4", bus_width, 2'b01);
  endtask

  task automatic t_switch_other;
    send(6, sw_arg(2'b11, 8'd183, 8'd7), 4'd4);
    send(6, sw_arg(2'b11, 8'd182, 8'd2), 4'd4);
    check("R4 other byte width", bus_width, 2'b01);
    check("R4 other byte err", switch_err, 1'b1);
    send(6, sw_arg(2'b01, 8'd183, 8'd2), 4'd4);
    check("R4 other access width", bus_width, 2'b01);
    check("R4 other access err", switch_err, 1'b1);
  endtask

  task automatic t_acmd_ok;
    send(0, 32'd0, 4'd4);
    send(55, 32'd0, 4'd4); send(6, 32'h2, 4'd4);
    check("R5 4 bit", bus_width, 2'b01);
    check("R5 no illegal", illegal_cmd, 1'b0);
    send(55, 32'd0, 4'd4); send(6, 32'h0, 4'd4);
    check("R5 1 bit", bus_width, 2'b00);
  endtask

  task automatic t_acmd_bad;
    send(55, 32'd0, 4'd4); send(6, 32'h2, 4'd4);
    send(55, 32'd0, 4'd4); send(6, 32'h1, 4'd4);
    check("R6 code 01 width", bus_width, 2'b01);
    check("R6 code 01 illegal", illegal_cmd, 1'b1);
    @(negedge clk);
    check("R10 pulse ends", illegal_cmd, 1'b0);
    send(55, 32'd0, 4'd4); send(6, 32'h3, 4'd4);
    check("R6 code 11 width", bus_width, 2'b01);
    check("R6 code 11 illegal", illegal_cmd, 1'b1);
  endtask

  task automatic t_acmd_state;
    send(55, 32'd0, 4'd3); send(6, 32'h0, 4'd3);
    check("R7 width kept", bus_width, 2'b01);
    check("R7 illegal", illegal_cmd, 1'b1);
    @(negedge clk);
    check("R10 low after", illegal_cmd, 1'b0);
  endtask

  task automatic t_prefix_life;
    send(55, 32'd0, 4'd4); send(13, 32'd0, 4'd4);
    send(6, sw_arg(2'b11, 8'd183, 8'd2), 4'd4);
    check("R8 switch path after other cmd", bus_width, 2'b10);
    send(55, 32'd0, 4'd4); send(55, 32'd0, 4'd4);
    send(6, 32'h2, 4'd4);
    check("R8 double prefix", bus_width, 2'b01);
  endtask

  task automatic t_go_idle;
    send(6, sw_arg(2'b11, 8'd183, 8'd2), 4'd4);
    send(6, sw_arg(2'b11, 8'd183, 8'd9), 4'd4);
    check("R3 pre idle err", switch_err, 1'b1);
    send(0, 32'd0, 4'd4);
    check("R9 width", bus_width, 2'b00);
    check("R9 err", switch_err, 1'b0);
    send(55, 32'd0, 4'd4); send(0, 32'd0, 4'd4);
    send(6, sw_arg(2'b11, 8'd183, 8'd1), 4'd4);
    check("R9 prefix cancelled", bus_width, 2'b01);
  endtask

  task automatic t_quiet;
    send(6, sw_arg(2'b11, 8'd183, 8'd5), 4'd4);
    @(negedge clk);
    cmd_index = 6'd6; cmd_arg = sw_arg(2'b11, 8'd183, 8'd2); card_state = 4'd4;
    repeat (4) @(negedge clk);
    check("R11 width", bus_width, 2'b01);
    check("R11 err", switch_err, 1'b1);
    cmd_index = 6'd0;
    repeat (2) @(negedge clk);
    check("R11 idle index ignored", bus_width, 2'b01);
    check("R10 no pulse", illegal_cmd, 1'b0);
  endtask

  initial begin
    t_reset;
    t_switch_valid;
    t_switch_invalid;
    t_switch_other;
    t_acmd_ok;
    t_acmd_bad;
    t_acmd_state;
    t_prefix_life;
    t_go_idle;
    t_quiet;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule